// File: doc/BRIEF.md
# Sector Write-Protection Guard

This block keeps the write-protection state of a flash array split into 64 uniform sectors of 64 KB. It says whether a program or erase may go ahead at a given address. Each sector has two kinds of state. The first is a reversible protect flag. The second is a one-way lockdown flag, which turns the sector into read-only storage for good. An input driven from the write-protect pin guards the protect flags: while it is asserted, no protect flag can be cleared. A freeze request closes the lockdown state against any further change.

Commands arrive as single-cycle strobes that carry an operation code and a byte address. Address bits [21:16] pick the sector. A permission query names an address, or it asks about the whole array for a chip erase. The answer appears one cycle later. A separate readback address returns, without delay, the protect flag and the lockdown flag of its sector.

Protect flags sit behind a soft reset that sets every one of them. Lockdown and freeze flags stand in for nonvolatile cells. They ignore the soft reset and clear only on the power-on reset.

Top module: `sector_guard`

## Requirements
- R1: While soft reset `rst_n` is low, every protect flag is set. After the reset is released, readback reports protect=1 for any sector until a command changes it.
- R2: The protect command (`cmd_op`=1) sets the protect flag of sector `cmd_addr[21:16]`. The unprotect command (`cmd_op`=2) clears it. No other sector changes. The new value can be read back on the cycle after the strobe.
- R3: The global protect command (`cmd_op`=3) sets all 64 protect flags at once. The global unprotect command (`cmd_op`=4) clears all of them at once.
- R4: While `wp_lock` is high, unprotect and global unprotect have no effect. Protect and global protect still work.
- R5: The lockdown command (`cmd_op`=5) sets the lockdown flag of the addressed sector. No command clears a lockdown flag, and a soft reset does not clear it either.
- R6: After the freeze command (`cmd_op`=6), lockdown commands have no effect. The frozen state survives a soft reset.
- R7: A single-sector query (`chk_valid`=1, `chk_chip`=0) produces `res_valid`=1 on the next cycle. `res_grant` is 1 only if the sector of `chk_addr` has neither its protect flag nor its lockdown flag set.
- R8: A chip-erase query (`chk_chip`=1) is granted only if no sector in the array is protected or locked down.
- R9: Power-on reset `por_n` low clears every lockdown flag and the freeze state.
- R10: `rd_prot` and `rd_lock` show, combinationally, the protect flag and the lockdown flag of sector `rd_addr[21:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears lockdown and freeze state |
| rst_n | input | 1 | Soft reset, active low, asynchronous; sets protect flags and clears the query result |
| wp_lock | input | 1 | Write-protect pin level, high = asserted |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 protect, 2 unprotect, 3 global protect, 4 global unprotect, 5 lockdown, 6 freeze |
| cmd_addr | input | 22 | Command byte address |
| chk_valid | input | 1 | Permission query strobe |
| chk_chip | input | 1 | Query covers the whole array |
| chk_addr | input | 22 | Query byte address |
| res_valid | output | 1 | Query answer present |
| res_grant | output | 1 | 1 = operation allowed |
| rd_addr | input | 22 | Readback byte address |
| rd_prot | output | 1 | Protect flag of the readback sector |
| rd_lock | output | 1 | Lockdown flag of the readback sector |

## Verification
The assertions assume that `por_n` is never released while `rst_n` is still meant to be active in a way that would skip the soft reset. The bench always pulls both resets low together at power-on. The assertions also assume that a query is never issued in the same cycle as a command that changes the flags the query reads. The bench keeps commands and queries in separate cycles and changes `wp_lock` only between commands. These rules make every answer depend on settled state alone.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PROT     = 3'd1,
    OP_UNPROT   = 3'd2,
    OP_ALL_PROT = 3'd3,
    OP_ALL_FREE = 3'd4,
    OP_LOCK     = 3'd5,
    OP_FREEZE   = 3'd6
  } sg_op_e;
endpackage

// File: rtl/sg_prot_bank.sv
module sg_prot_bank #(
  parameter int N_SECT = 64,
  localparam int SW = $clog2(N_SECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_lock,
  input  logic          cmd_valid,
  input  sg_pkg::sg_op_e cmd_op,
  input  logic [SW-1:0] cmd_sect,
  output logic [N_SECT-1:0] prot_q
);
  import sg_pkg::*;

  // Decode once, shared by every sector slice.
  logic set_one, clr_one, set_all, clr_all;
  always_comb begin
    set_one = cmd_valid && (cmd_op == OP_PROT);
    clr_one = cmd_valid && (cmd_op == OP_UNPROT) && !wp_lock;
    set_all = cmd_valid && (cmd_op == OP_ALL_PROT);
    clr_all = cmd_valid && (cmd_op == OP_ALL_FREE) && !wp_lock;
  end

  for (genvar i = 0; i < N_SECT; i++) begin : g_sect
    logic hit;
    assign hit = (cmd_sect == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prot_q[i] <= 1'b1;
      else if (set_all || (set_one && hit))
        prot_q[i] <= 1'b1;
      else if (clr_all || (clr_one && hit))
        prot_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
  parameter int N_SECT = 64,
  localparam int SW = $clog2(N_SECT)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cmd_valid,
  input  sg_pkg::sg_op_e cmd_op,
  input  logic [SW-1:0] cmd_sect,
  output logic [N_SECT-1:0] lock_q,
  output logic          freeze_q
);
  import sg_pkg::*;

  logic lock_req;
  assign lock_req = cmd_valid && (cmd_op == OP_LOCK) && !freeze_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      freeze_q <= 1'b0;
    else if (cmd_valid && (cmd_op == OP_FREEZE))
      freeze_q <= 1'b1;
  end

  for (genvar i = 0; i < N_SECT; i++) begin : g_sect
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
        lock_q[i] <= 1'b0;
      else if (lock_req && (cmd_sect == SW'(i)))
        lock_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sg_judge.sv
module sg_judge #(
  parameter int N_SECT = 64,
  localparam int SW = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SECT-1:0] prot_q,
  input  logic [N_SECT-1:0] lock_q,
  input  logic              chk_valid,
  input  logic              chk_chip,
  input  logic [SW-1:0]     chk_sect,
  output logic              res_valid,
  output logic              res_grant
);
  logic [N_SECT-1:0] barred;
  logic              ok_now;

  always_comb begin
    barred = prot_q | lock_q;
    ok_now = chk_chip ? ~|barred : ~barred[chk_sect];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
    end else begin
      res_valid <= chk_valid;
      res_grant <= chk_valid && ok_now;
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int N_SECT = 64,
  parameter int ADDR_W = 22,
  localparam int SW  = $clog2(N_SECT),
  localparam int LSB = ADDR_W - SW
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wp_lock,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              chk_valid,
  input  logic              chk_chip,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              res_valid,
  output logic              res_grant,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_prot,
  output logic              rd_lock
);
  import sg_pkg::*;

  sg_op_e            op;
  logic [SW-1:0]     cmd_sect, chk_sect, rd_sect;
  logic [N_SECT-1:0] prot_q, lock_q;
  logic              freeze_q;
  logic              unused_low;

  assign op         = sg_op_e'(cmd_op);
  assign cmd_sect   = cmd_addr[ADDR_W-1:LSB];
  assign chk_sect   = chk_addr[ADDR_W-1:LSB];
  assign rd_sect    = rd_addr[ADDR_W-1:LSB];
  assign unused_low = ^{cmd_addr[LSB-1:0], chk_addr[LSB-1:0], rd_addr[LSB-1:0]};

  sg_prot_bank #(.N_SECT(N_SECT)) u_prot (
    .clk(clk), .rst_n(rst_n), .wp_lock(wp_lock), .cmd_valid(cmd_valid),
    .cmd_op(op), .cmd_sect(cmd_sect), .prot_q(prot_q)
  );

  sg_lock_bank #(.N_SECT(N_SECT)) u_lock (
    .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_op(op),
    .cmd_sect(cmd_sect), .lock_q(lock_q), .freeze_q(freeze_q)
  );

  sg_judge #(.N_SECT(N_SECT)) u_judge (
    .clk(clk), .rst_n(rst_n), .prot_q(prot_q), .lock_q(lock_q),
    .chk_valid(chk_valid), .chk_chip(chk_chip), .chk_sect(chk_sect),
    .res_valid(res_valid), .res_grant(res_grant)
  );

  assign rd_prot = prot_q[rd_sect];
  assign rd_lock = lock_q[rd_sect];
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int N_SECT = 64
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wp_lock,
  input logic              chk_valid,
  input logic              chk_chip,
  input logic              res_valid,
  input logic              res_grant,
  input logic [N_SECT-1:0] prot_q,
  input logic [N_SECT-1:0] lock_q,
  input logic              freeze_q
);
  // R7: one answer per query, exactly one cycle later
  p_answer_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);

  // R4: with the pin asserted no protect flag may fall
  p_wp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_lock |=> !(|($past(prot_q) & ~prot_q)));

  // R5: lockdown flags never fall while power stays up
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    !(|($past(lock_q) & ~lock_q)));

  // R6: frozen means the lockdown set no longer moves, and freeze stays
  p_frozen_still_r6: assert property (@(posedge clk) disable iff (!por_n)
    freeze_q |=> $stable(lock_q));
  p_freeze_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    freeze_q |=> freeze_q);

  // R8: any barred sector denies a chip-wide query
  p_chip_deny_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (chk_valid && chk_chip && |(prot_q | lock_q)) |=> !res_grant);

  // R7: a grant only ever comes with an answer
  p_grant_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_grant |-> res_valid);
endmodule

bind sector_guard sg_guard_chk #(.N_SECT(N_SECT)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_lock(wp_lock),
  .chk_valid(chk_valid), .chk_chip(chk_chip), .res_valid(res_valid),
  .res_grant(res_grant), .prot_q(prot_q), .lock_q(lock_q), .freeze_q(freeze_q)
);

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, wp_lock = 1'b0;
  logic cmd_valid = 1'b0, chk_valid = 1'b0, chk_chip = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [21:0] cmd_addr = '0, chk_addr = '0, rd_addr = '0;
  logic res_valid, res_grant, rd_prot, rd_lock;

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_guard u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_lock(wp_lock),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .chk_valid(chk_valid), .chk_chip(chk_chip), .chk_addr(chk_addr),
    .res_valid(res_valid), .res_grant(res_grant),
    .rd_addr(rd_addr), .rd_prot(rd_prot), .rd_lock(rd_lock)
  );

  function automatic logic [21:0] sa(input int s);
    return {s[5:0], 16'h3A5C};
  endfunction

  task automatic cmd(input logic [2:0] op, input int s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = sa(s);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  // Driver: pushes the expected answer, monitor compares it
  task automatic query(input bit chip, input int s, input bit exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    chk_valid = 1'b1; chk_chip = chip; chk_addr = sa(s);
    @(negedge clk);
    chk_valid = 1'b0; chk_chip = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(input int s, input bit ep, input bit el, input string tag);
    rd_addr = sa(s);
    #1;
    total++;
    if (rd_prot !== ep || rd_lock !== el) begin
      bad++;
      $display("FAIL %s sector %0d: prot/lock=%b%b expected %b%b", tag, s, rd_prot, rd_lock, ep, el);
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (res_valid === 1'b1) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected answer: res_grant=%b expected none", res_grant);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (res_grant !== e) begin
          bad++;
          $display("FAIL %s: res_grant=%b expected %b", t, res_grant, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: reset state
    look(0, 1, 0, "R1 reset prot");
    look(37, 1, 0, "R9 reset lock");
    look(63, 1, 0, "R1 reset prot");
    query(1, 0, 0, "R8 chip denied after reset");
    query(0, 5, 0, "R7 sector denied after reset");
    // R2: single sector
    cmd(3'd2, 5);
    look(5, 0, 0, "R2 unprotect");
    look(4, 1, 0, "R2 neighbour untouched");
    query(0, 5, 1, "R7 free sector granted");
    query(0, 4, 0, "R7 protected sector denied");
    // R3: global clear
    cmd(3'd4, 0);
    look(63, 0, 0, "R3 global unprotect");
    query(1, 0, 1, "R8 chip granted when clear");
    cmd(3'd1, 10);
    look(10, 1, 0, "R2 protect");
    look(11, 0, 0, "R2 neighbour untouched");
    query(0, 10, 0, "R7 protected denied");
    query(1, 0, 0, "R8 one protected sector denies chip");
    // R4: write-protect pin
    @(negedge clk); wp_lock = 1'b1;
    cmd(3'd2, 10);
    look(10, 1, 0, "R4 unprotect ignored");
    cmd(3'd4, 0);
    look(10, 1, 0, "R4 global unprotect ignored");
    cmd(3'd1, 20);
    look(20, 1, 0, "R4 protect still works");
    cmd(3'd3, 0);
    look(33, 1, 0, "R3 global protect under pin");
    @(negedge clk); wp_lock = 1'b0;
    cmd(3'd4, 0);
    look(20, 0, 0, "R3 global unprotect after pin");
    // R5: lockdown
    cmd(3'd5, 7);
    look(7, 0, 1, "R5 lockdown set");
    look(6, 0, 0, "R5 neighbour unlocked");
    query(0, 7, 0, "R7 locked sector denied");
    cmd(3'd2, 7);
    cmd(3'd4, 0);
    look(7, 0, 1, "R5 unprotect keeps lock");
    soft_reset();
    look(7, 1, 1, "R5 lock survives soft reset");
    look(40, 1, 0, "R1 soft reset sets prot");
    cmd(3'd4, 0);
    query(0, 8, 1, "R7 free sector granted");
    query(0, 7, 0, "R5 locked sector still denied");
    query(1, 0, 0, "R8 locked sector denies chip");
    // R6: freeze
    cmd(3'd6, 0);
    cmd(3'd5, 9);
    look(9, 0, 0, "R6 lockdown ignored when frozen");
    soft_reset();
    cmd(3'd5, 11);
    look(11, 1, 0, "R6 freeze survives soft reset");
    cmd(3'd4, 0);
    query(0, 9, 1, "R6 unlocked sector granted");
    // R9: power-on clears lock and freeze
    power_on();
    look(7, 1, 0, "R9 lock cleared");
    cmd(3'd4, 0);
    query(1, 0, 1, "R9 chip granted after power-on");
    cmd(3'd5, 12);
    look(12, 0, 1, "R9 freeze cleared");
    // R10: readback follows address without delay
    rd_addr = sa(13); #1;
    total++;
    if (rd_lock !== 1'b0) begin bad++; $display("FAIL R10 rd_lock=%b expected 0", rd_lock); end
    rd_addr = sa(12); #1;
    total++;
    if (rd_lock !== 1'b1) begin bad++; $display("FAIL R10 rd_lock=%b expected 1", rd_lock); end
    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R7 missing answers: pending=%0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule